// File: doc/BRIEF.md
# Serial Nibble Register Port

This block is a bit-serial slave port that lets a host reach a sixteen-entry space of 4-bit registers over four wires: a chip select, a serial clock, a data input and a data output. Each transfer starts when chip select goes high. The host shifts in one address nibble, least significant bit first, then one data nibble. A direction input, sampled when the transfer begins, decides whether the data nibble is written into the port or shifted out of it.

Addresses 0x0 to 0xC present the BCD digits of the time and date, which a separate counter block supplies on a flat input vector. Address 0xF is a control register that holds a 2-bit mode and a one-bit system flag. Any nonzero mode banks the time digits out of view. All serial lines are brought into the system clock domain through synchronisers. The port acts on each rising edge of the serial clock that it sees after synchronisation.

Top module: `snri_port`

## Requirements
- R1: The first four serial-clock rising edges of a transfer form the address nibble, and the first bit received is address bit 0.
- R2: In a read, the k-th data-phase rising edge (k = 0 to 3) places bit k of the selected register on `sdo_o`, which holds that value until the next rising edge.
- R3: With mode zero, reading address n for n from 0 to 12 returns `time_digits_i[4n+3:4n]`, and reading 0xD or 0xE returns zero.
- R4: Writing address 0xF stores data bits [1:0] as the mode and data bit 3 as the system flag, and discards bit 2. Reading 0xF returns the system flag in bit 3, zero in bit 2 and the mode in bits [1:0].
- R5: While the mode is nonzero, reads of every address other than 0xF return zero. Reads return to normal once the mode is written back to zero.
- R6: Writes to any address other than 0xF change no register state.
- R7: A write takes effect only once the fourth data bit has been received. Dropping chip select before that point stores nothing.
- R8: While chip select is low, the port returns to the address phase and drives `sdo_o` low. A transfer started afterwards decodes a fresh address.
- R9: `dir_i` high selects a read and low selects a write. It is sampled while chip select is low, and changes to it during a transfer have no effect.
- R10: Reset clears the mode and the system flag, so the time digits are visible, and drives `sdo_o` low.
- R11: Serial-clock edges that arrive after the data nibble are ignored until chip select drops, and `sdo_o` keeps the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data from the host |
| dir_i | input | 1 | Transfer direction, 1 = read, 0 = write |
| time_digits_i | input | 52 | Thirteen BCD digits; digit n occupies bits [4n+3:4n] |
| sdo_o | output | 1 | Serial data to the host |

## Verification
The assertions assume that every serial line stays at each level for at least as many system-clock cycles as the synchroniser has stages. They also assume that `dir_i` is settled before chip select rises. Without those conditions, an edge could be missed or a direction sampled mid-change. The stimulus holds each serial level for six system clocks, drives `dir_i` several cycles before raising chip select, and flips `dir_i` deliberately only after a transfer has begun. The time digits change only while chip select is low, so a digit never changes in the middle of a bit being shifted out.

// File: rtl/snri_pkg.sv
package snri_pkg;

    localparam int NIB_W     = 4;
    localparam int ADDR_W    = 4;
    localparam int DIGITS    = 13;
    localparam int CNT_W     = $clog2(NIB_W);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [NIB_W-1:0]    shreg;
        logic [ADDR_W-1:0]   addr;
        logic                rd;
        logic                sdo;
        logic                sclk_prev;
    } port_state_t;

    typedef struct packed {
        logic       sys;
        logic [1:0] mode;
    } ctrl_state_t;

endpackage

// File: rtl/snri_sync.sv
module snri_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= stg_d[k];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/snri_regmap.sv
module snri_regmap
    import snri_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [NIB_W-1:0]        wr_data,
    input  logic [DIGITS*NIB_W-1:0] digits,
    output logic [NIB_W-1:0]        rdata
);

    ctrl_state_t ctrl_d, ctrl_q;
    logic        unused_wr_bit2;

    assign unused_wr_bit2 = wr_data[2];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_addr == CTRL_ADDR) begin
            ctrl_d.mode = wr_data[1:0];
            ctrl_d.sys  = wr_data[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_addr == CTRL_ADDR) begin
            rdata = {ctrl_q.sys, 1'b0, ctrl_q.mode};
        end else if (ctrl_q.mode == 2'd0) begin
            for (int i = 0; i < DIGITS; i++) begin
                if (rd_addr == ADDR_W'(i)) rdata = digits[i*NIB_W +: NIB_W];
            end
        end
    end

    // Control state moves only on a write aimed at the control address.
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == CTRL_ADDR) |=> $stable(ctrl_q));

    // At most one commit per transfer.
    assert_single_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/snri_port.sv
module snri_port
    import snri_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_i,
    input  logic        sclk_i,
    input  logic        sdi_i,
    input  logic        dir_i,
    input  logic [51:0] time_digits_i,
    output logic        sdo_o
);

    logic [3:0]        sync_out;
    logic              cs_s, sclk_s, sdi_s, dir_s;
    port_state_t       s_d, s_q;
    logic              rise;
    logic [NIB_W-1:0]  shift_in;
    logic [NIB_W-1:0]  rdata;
    logic              wr_en;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIB_W - 1);

    snri_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({dir_i, sdi_i, sclk_i, cs_i}),
        .dout (sync_out)
    );

    assign {dir_s, sdi_s, sclk_s, cs_s} = sync_out;

    always_comb begin
        s_d          = s_q;
        wr_en        = 1'b0;
        s_d.sclk_prev = sclk_s;
        rise         = sclk_s & ~s_q.sclk_prev;
        shift_in     = {sdi_s, s_q.shreg[NIB_W-1:1]};
        if (!cs_s) begin
            s_d.phase = PH_ADDR;
            s_d.cnt   = '0;
            s_d.shreg = '0;
            s_d.sdo   = 1'b0;
            s_d.rd    = dir_s;
        end else if (rise) begin
            case (s_q.phase)
                PH_ADDR: begin
                    s_d.shreg = shift_in;
                    s_d.cnt   = s_q.cnt + 1'b1;
                    if (s_q.cnt == LAST) begin
                        s_d.addr  = shift_in;
                        s_d.phase = PH_DATA;
                        s_d.cnt   = '0;
                        s_d.shreg = '0;
                    end
                end
                PH_DATA: begin
                    s_d.shreg = shift_in;
                    s_d.sdo   = s_q.rd & rdata[s_q.cnt];
                    s_d.cnt   = s_q.cnt + 1'b1;
                    if (s_q.cnt == LAST) begin
                        wr_en     = ~s_q.rd;
                        s_d.phase = PH_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    snri_regmap i_regmap (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(s_q.addr),
        .wr_en  (wr_en),
        .wr_addr(s_q.addr),
        .wr_data(shift_in),
        .digits (time_digits_i),
        .rdata  (rdata)
    );

    assign sdo_o = s_q.sdo;

    assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !sdo_o);

    assert_addr_phase_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> s_q.phase == PH_ADDR);

    assert_dir_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> $stable(s_q.rd));

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DONE && cs_s) |=> $stable(sdo_o));

endmodule

// File: tb/test_snri_port.sv
module test_snri_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_tb = 1'b0, sclk_tb = 1'b0, sdi_tb = 1'b0, dir_tb = 1'b0;
    logic [51:0] digits_tb = '0;
    logic        sdo;

    int checks = 0;
    int fails  = 0;
    bit idle_mon = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference state
    int m_mode = 0;
    int m_sys  = 0;

    always #4 clk = ~clk;

    snri_port i_snri_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_i         (cs_tb),
        .sclk_i       (sclk_tb),
        .sdi_i        (sdi_tb),
        .dir_i        (dir_tb),
        .time_digits_i(digits_tb),
        .sdo_o        (sdo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] model_read(input logic [3:0] a);
        if (a == 4'hF) return {m_sys[0], 1'b0, m_mode[1:0]};
        if (m_mode != 0) return 4'h0;
        if (a < 4'd13) return digits_tb[a*4 +: 4];
        return 4'h0;
    endfunction

    // Idle comparison on every clock: with chip select low and settled, output is low.
    always @(negedge clk) begin
        if (rst_n && idle_mon && !finished) check(sdo == 1'b0, "R8 idle", sdo, 0);
    end

    task automatic xfer(input bit rd, input logic [3:0] addr, input logic [3:0] wd,
                        input int stop_at, input int extra, input string req,
                        output logic [3:0] got);
        logic [3:0] exp;
        exp = model_read(addr);
        got = '0;
        dir_tb = rd;
        wclk(6);
        idle_mon = 1'b0;
        cs_tb = 1'b1;
        wclk(6);
        for (int k = 0; k < 8; k++) begin
            if (k == stop_at) break;
            sdi_tb = (k < 4) ? addr[k] : (rd ? 1'b0 : wd[k-4]);
            if (k == 4) dir_tb = ~rd;   // R9: change after start must not matter
            wclk(3);
            sclk_tb = 1'b1;
            wclk(6);
            if (k >= 4 && rd) begin
                got[k-4] = sdo;
                check(sdo == exp[k-4], req, sdo, exp[k-4]);
            end
            sclk_tb = 1'b0;
            wclk(6);
        end
        for (int e = 0; e < extra; e++) begin
            sdi_tb = ~sdi_tb;
            sclk_tb = 1'b1;
            wclk(6);
            sclk_tb = 1'b0;
            wclk(6);
            check(sdo == exp[3], "R11 extra clocks", sdo, exp[3]);
        end
        cs_tb = 1'b0;
        sdi_tb = 1'b0;
        wclk(6);
        check(sdo == 1'b0, "R8 after cs drop", sdo, 0);
        idle_mon = 1'b1;
        if (!rd && stop_at >= 8 && addr == 4'hF) begin
            m_mode = wd[1:0];
            m_sys  = wd[3];
        end
    endtask

    task automatic do_read(input logic [3:0] a, input string req);
        logic [3:0] g, e;
        e = model_read(a);
        xfer(1'b1, a, 4'h0, 8, 0, req, g);
        check(g == e, req, g, e);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d, input string req);
        logic [3:0] g;
        xfer(1'b0, a, d, 8, 0, req, g);
    endtask

    function automatic logic [51:0] pattern(input int mul, input int add);
        logic [51:0] v;
        v = '0;
        for (int i = 0; i < 13; i++) v[i*4 +: 4] = 4'((i*mul + add) % 10);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] g;
        digits_tb = pattern(3, 1);
        wclk(5);
        check(sdo == 1'b0, "R10 sdo in reset", sdo, 0);
        rst_n = 1'b1;
        wclk(5);
        check(sdo == 1'b0, "R10 sdo after reset", sdo, 0);
        idle_mon = 1'b1;
        do_read(4'hF, "R10 ctrl after reset");

        // R1 R2 R3: full map, two digit patterns
        for (int a = 0; a < 13; a++) do_read(4'(a), "R3 digit pattern A (R1 R2)");
        do_read(4'hD, "R3 unused 0xD");
        do_read(4'hE, "R3 unused 0xE");
        digits_tb = pattern(7, 2);
        for (int a = 0; a < 13; a++) do_read(4'(a), "R3 digit pattern B (R1 R2)");

        // R11: extra clocks after the data nibble
        xfer(1'b1, 4'h4, 4'h0, 8, 2, "R11 read then extra", g);

        // R4: control write and readback
        do_write(4'hF, 4'hB, "R4 write ctrl");
        do_read(4'hF, "R4 ctrl readback 0xB");

        // R5: banked reads
        for (int a = 0; a < 13; a++) do_read(4'(a), "R5 hidden digit");

        // R6: write to a non-control address changes nothing
        do_write(4'h5, 4'h9, "R6 write digit");
        do_read(4'hF, "R6 ctrl unchanged");

        // R4: bit 2 discarded
        do_write(4'hF, 4'hD, "R4 write ctrl 0xD");
        do_read(4'hF, "R4 bit2 discarded");

        // R7: abort during write data
        xfer(1'b0, 4'hF, 4'h0, 7, 0, "R7 aborted write", g);
        do_read(4'hF, "R7 ctrl after abort");

        // R8: abort in address phase then a fresh transfer
        xfer(1'b1, 4'h3, 4'h0, 2, 0, "R8 aborted addr", g);
        do_read(4'hF, "R8 fresh transfer");

        // R5 R9: clear mode (dir flips mid-transfer), digits return
        do_write(4'hF, 4'h0, "R9 write with dir flip");
        do_read(4'hF, "R9 write committed");
        do_read(4'h6, "R5 digits visible again");
        do_read(4'hC, "R5 digits visible again");

        // R10: reset clears control
        do_write(4'hF, 4'hA, "R4 write ctrl 0xA");
        do_read(4'hF, "R4 ctrl readback 0xA");
        idle_mon = 1'b0;
        rst_n = 1'b0;
        wclk(3);
        rst_n = 1'b1;
        m_mode = 0;
        m_sys  = 0;
        wclk(4);
        idle_mon = 1'b1;
        do_read(4'hF, "R10 ctrl cleared");
        do_read(4'h3, "R10 digits visible");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule